// File: doc/BRIEF.md
# Root Port Error Message Collector

This block sits in a root port and gathers the error messages that arrive from devices below it. Each message carries a severity (correctable, nonfatal or fatal) and a 16-bit requester ID. The block keeps a root error status register, with received, multiple-received and first-fatal flags, and a 32-bit source register that holds the requester ID of the first correctable error in its low half and of the first uncorrectable error in its high half. Software clears the report flags by writing ones and enables interrupt generation per severity through a 3-bit root command register.

The interrupt condition is "some enabled severity has its received flag set". When message-signalled interrupts are enabled, the block emits a one-cycle `msi_pulse` only when that condition goes from false to true, whether a message or a command write causes it. When they are disabled, it drives a legacy level, `intx_level`. A small state machine tracks that level. It has two states. IRQ_QUIET is the reset state. IRQ_ASSERTED is entered on a raise event, and also on a command write that leaves the condition true. The machine returns from IRQ_ASSERTED to IRQ_QUIET on a command write that leaves the condition false. The level is therefore re-evaluated on every command write and latched by messages. An interrupt message number field in the status register is loaded every cycle from a device-specific input.

Top module: `rp_err_collector`

## Requirements
- R1: After reset, `root_cmd` is 0, `root_sts[26:0]` is 0, `err_src_id` is 0, and `msi_pulse` and `intx_level` are low.
- R2: `msg_sev` encodes correctable as 0. A correctable message sets `root_sts[0]` and writes its ID into `err_src_id[15:0]` when bit 0 was clear. When bit 0 was already set, it sets `root_sts[1]` and leaves the ID field unchanged.
- R3: `msg_sev` encodes nonfatal as 1 and fatal as 2. Both are uncorrectable. An uncorrectable message sets `root_sts[2]` and writes its ID into `err_src_id[31:16]` when bit 2 was clear. When bit 2 was already set, it sets `root_sts[3]` and leaves the ID field unchanged.
- R4: A fatal message sets `root_sts[6]`, and also sets `root_sts[4]` only if `root_sts[2]` was clear before it. A nonfatal message sets `root_sts[5]`.
- R5: A message with `msg_sev` = 3 changes no status bit, no source ID and no interrupt output.
- R6: Each 1 in `rpt_w1c[6:0]` clears the matching `root_sts` bit, and `cmd_wr` loads `cmd_wdata` into `root_cmd`. The clear is applied before a message in the same cycle, so the message's set wins and it is judged against the cleared flags.
- R7: `root_sts[31:27]` equals `msg_num_in` from the previous cycle and is untouched by `rpt_w1c`. `root_sts[26:7]` reads 0.
- R8: Enable bit 0 of `root_cmd` covers correctable, bit 1 nonfatal and bit 2 fatal, and these map onto status bits 0, 5 and 6. With `msi_en` high, a message produces a one-cycle `msi_pulse` in the cycle after it only when the enabled condition was false before the message and is true after it.
- R9: With `msi_en` high, a command write pulses `msi_pulse` when it turns the enabled condition from false to true, and does not pulse when the condition was already true.
- R10: With `msi_en` low, `intx_level` rises after a message that makes the enabled condition true, with no `msi_pulse`. Every command write sets the level to the new enabled condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Error message strobe |
| msg_sev | input | 2 | Severity: 0 correctable, 1 nonfatal, 2 fatal, 3 ignored |
| msg_src_id | input | 16 | Requester ID of the message |
| cmd_wr | input | 1 | Root command write strobe |
| cmd_wdata | input | 3 | Enables: bit0 correctable, bit1 nonfatal, bit2 fatal |
| rpt_w1c | input | 7 | Write-one-to-clear mask for status bits 6..0 |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| msg_num_in | input | 5 | Interrupt message number from the device |
| root_cmd | output | 3 | Root command register |
| root_sts | output | 32 | Root status: report flags [6:0], message number [31:27] |
| err_src_id | output | 32 | First uncorrectable ID [31:16], first correctable ID [15:0] |
| msi_pulse | output | 1 | One-cycle interrupt message request |
| intx_level | output | 1 | Legacy interrupt level |

## Verification
The hardest cases to reach from the ports are those where a software clear and a new message land in the same cycle. In these cases the message must count as a first error rather than a repeat, and it must still raise the interrupt. The bench first builds a set flag, then drives `rpt_w1c` and `msg_valid` on the same edge, and checks that the source ID is recaptured, that no multiple flag appears and that a pulse fires. A second hard case is a message or command write that arrives while the condition is already true, where the pulse must be suppressed. The bench sets up each enable and status combination on purpose before sending that stimulus.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;
    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_RSVD     = 2'd3
    } sev_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_ASSERTED
    } irq_state_e;

    localparam int RPT_W  = 7;
    localparam int CMD_W  = 3;
    localparam int B_COR  = 0;
    localparam int B_MCOR = 1;
    localparam int B_UNC  = 2;
    localparam int B_MUNC = 3;
    localparam int B_FFAT = 4;
    localparam int B_NF   = 5;
    localparam int B_FAT  = 6;

    // received flags mapped onto command enable positions {fatal, nonfatal, cor}
    function automatic logic [CMD_W-1:0] rpt_to_en(input logic [RPT_W-1:0] r);
        return {r[B_FAT], r[B_NF], r[B_COR]};
    endfunction
endpackage

// File: rtl/rp_err_status.sv
module rp_err_status
    import rp_err_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msg_valid,
    input  logic [1:0]           msg_sev,
    input  logic [SRC_W-1:0]     msg_src_id,
    input  logic [RPT_W-1:0]     rpt_w1c,
    output logic                 msg_ok,
    output logic [RPT_W-1:0]     rpt_q,
    output logic [RPT_W-1:0]     rpt_pre,
    output logic [RPT_W-1:0]     rpt_nxt,
    output logic [2*SRC_W-1:0]   src_q
);
    logic [2*SRC_W-1:0] src_nxt;
    sev_e               sev;

    assign sev = sev_e'(msg_sev);

    always_comb begin
        rpt_pre = rpt_q & ~rpt_w1c;
        rpt_nxt = rpt_pre;
        src_nxt = src_q;
        msg_ok  = msg_valid && (sev != SEV_RSVD);
        if (msg_ok) begin
            unique case (sev)
                SEV_COR: begin
                    if (rpt_pre[B_COR]) rpt_nxt[B_MCOR] = 1'b1;
                    else                src_nxt[SRC_W-1:0] = msg_src_id;
                    rpt_nxt[B_COR] = 1'b1;
                end
                SEV_NONFATAL: rpt_nxt[B_NF] = 1'b1;
                SEV_FATAL: begin
                    if (!rpt_pre[B_UNC]) rpt_nxt[B_FFAT] = 1'b1;
                    rpt_nxt[B_FAT] = 1'b1;
                end
                default: ;
            endcase
            if (sev != SEV_COR) begin
                if (rpt_pre[B_UNC]) rpt_nxt[B_MUNC] = 1'b1;
                else                src_nxt[2*SRC_W-1:SRC_W] = msg_src_id;
                rpt_nxt[B_UNC] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_q <= '0;
            src_q <= '0;
        end else begin
            rpt_q <= rpt_nxt;
            src_q <= src_nxt;
        end
    end
endmodule

// File: rtl/rp_err_irq.sv
module rp_err_irq
    import rp_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_ok,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_q,
    input  logic [CMD_W-1:0] cmd_nxt,
    input  logic [RPT_W-1:0] rpt_pre,
    input  logic [RPT_W-1:0] rpt_nxt,
    input  logic             msi_en,
    output logic             msi_pulse,
    output logic             intx_level
);
    irq_state_e state_q, state_nxt;
    logic       cond_pre, cond_post, raise;

    always_comb begin
        cond_pre  = |(cmd_q & rpt_to_en(rpt_pre));
        cond_post = |(cmd_nxt & rpt_to_en(rpt_nxt));
        raise     = (msg_ok || cmd_wr) && !cond_pre && cond_post;
        state_nxt = state_q;
        unique case (state_q)
            IRQ_QUIET:
                if (raise || (cmd_wr && cond_post)) state_nxt = IRQ_ASSERTED;
            IRQ_ASSERTED:
                if (cmd_wr && !cond_post) state_nxt = IRQ_QUIET;
            default: state_nxt = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) msi_pulse <= 1'b0;
        else        msi_pulse <= raise && msi_en;
    end

    assign intx_level = (state_q == IRQ_ASSERTED) && !msi_en;
endmodule

// File: rtl/rp_err_collector.sv
module rp_err_collector
    import rp_err_pkg::*;
#(
    parameter int SRC_W    = 16,
    parameter int MSGNUM_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msg_valid,
    input  logic [1:0]          msg_sev,
    input  logic [SRC_W-1:0]    msg_src_id,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_wdata,
    input  logic [RPT_W-1:0]    rpt_w1c,
    input  logic                msi_en,
    input  logic [MSGNUM_W-1:0] msg_num_in,
    output logic [CMD_W-1:0]    root_cmd,
    output logic [31:0]         root_sts,
    output logic [2*SRC_W-1:0]  err_src_id,
    output logic                msi_pulse,
    output logic                intx_level
);
    localparam int PAD_W = 32 - MSGNUM_W - RPT_W;

    logic [CMD_W-1:0]    cmd_q, cmd_nxt;
    logic [MSGNUM_W-1:0] msgnum_q;
    logic [RPT_W-1:0]    rpt_q, rpt_pre, rpt_nxt;
    logic                msg_ok;

    assign cmd_nxt = cmd_wr ? cmd_wdata : cmd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            msgnum_q <= '0;
        end else begin
            cmd_q    <= cmd_nxt;
            msgnum_q <= msg_num_in;
        end
    end

    rp_err_status #(.SRC_W(SRC_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_valid  (msg_valid),
        .msg_sev    (msg_sev),
        .msg_src_id (msg_src_id),
        .rpt_w1c    (rpt_w1c),
        .msg_ok     (msg_ok),
        .rpt_q      (rpt_q),
        .rpt_pre    (rpt_pre),
        .rpt_nxt    (rpt_nxt),
        .src_q      (err_src_id)
    );

    rp_err_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .msg_ok     (msg_ok),
        .cmd_wr     (cmd_wr),
        .cmd_q      (cmd_q),
        .cmd_nxt    (cmd_nxt),
        .rpt_pre    (rpt_pre),
        .rpt_nxt    (rpt_nxt),
        .msi_en     (msi_en),
        .msi_pulse  (msi_pulse),
        .intx_level (intx_level)
    );

    assign root_cmd = cmd_q;
    assign root_sts = {msgnum_q, {PAD_W{1'b0}}, rpt_q};
endmodule

// File: rtl/rp_err_collector_chk.sv
module rp_err_collector_chk #(
    parameter int SRC_W    = 16,
    parameter int MSGNUM_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                msg_valid,
    input logic                cmd_wr,
    input logic [6:0]          rpt_w1c,
    input logic                msi_en,
    input logic [MSGNUM_W-1:0] msg_num_in,
    input logic [2:0]          root_cmd,
    input logic [31:0]         root_sts,
    input logic [2*SRC_W-1:0]  err_src_id,
    input logic                msi_pulse
);
    AST_COR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (root_sts[0] && !rpt_w1c[0]) |=> $stable(err_src_id[SRC_W-1:0])); // R2
    AST_UNC_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (root_sts[2] && !rpt_w1c[2]) |=> $stable(err_src_id[2*SRC_W-1:SRC_W])); // R3
    AST_FIRST_FATAL_WITH_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_sts[4]) |-> (root_sts[6] && root_sts[2])); // R4
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(root_cmd)); // R6
    AST_MSGNUM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (root_sts[31:27] == $past(msg_num_in))); // R7
    AST_PULSE_NEEDS_MSI: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> $past(msi_en)); // R8
    AST_PULSE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> $past(msg_valid || cmd_wr)); // R9
endmodule

bind rp_err_collector rp_err_collector_chk #(.SRC_W(SRC_W), .MSGNUM_W(MSGNUM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .msg_valid  (msg_valid),
    .cmd_wr     (cmd_wr),
    .rpt_w1c    (rpt_w1c),
    .msi_en     (msi_en),
    .msg_num_in (msg_num_in),
    .root_cmd   (root_cmd),
    .root_sts   (root_sts),
    .err_src_id (err_src_id),
    .msi_pulse  (msi_pulse)
);

// File: tb/rp_err_collector_bench.sv
`timescale 1ns/1ps
module rp_err_collector_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src_id = 16'd0;
    logic        cmd_wr = 1'b0;
    logic [2:0]  cmd_wdata = 3'd0;
    logic [6:0]  rpt_w1c = 7'd0;
    logic        msi_en = 1'b0;
    logic [4:0]  msg_num_in = 5'd9;
    logic [2:0]  root_cmd;
    logic [31:0] root_sts;
    logic [31:0] err_src_id;
    logic        msi_pulse;
    logic        intx_level;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rp_err_collector u_rp_err_collector (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src_id(msg_src_id), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .rpt_w1c(rpt_w1c), .msi_en(msi_en), .msg_num_in(msg_num_in),
        .root_cmd(root_cmd), .root_sts(root_sts), .err_src_id(err_src_id),
        .msi_pulse(msi_pulse), .intx_level(intx_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_msg(input logic [1:0] sev, input logic [15:0] id);
        msg_valid = 1'b1; msg_sev = sev; msg_src_id = id;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wr_cmd(input logic [2:0] v);
        cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic clear_all();
        rpt_w1c = 7'h7f;
        @(negedge clk);
        rpt_w1c = 7'h00;
    endtask

    task automatic t_reset();
        chk("R1 cmd", {29'd0, root_cmd}, 32'd0);
        chk("R1 sts", {5'd0, root_sts[26:0]}, 32'd0);
        chk("R1 src", err_src_id, 32'd0);
        chk("R1 irq", {30'd0, msi_pulse, intx_level}, 32'd0);
        chk("R7 msgnum after reset", {27'd0, root_sts[31:27]}, 32'd9);
    endtask

    task automatic t_correctable();
        msi_en = 1'b1;
        send_msg(2'd0, 16'h1234);
        chk("R2 first cor sts", {25'd0, root_sts[6:0]}, 32'h01);
        chk("R2 first cor src", err_src_id, 32'h0000_1234);
        chk("R8 no pulse cmd off", {31'd0, msi_pulse}, 32'd0);
        send_msg(2'd0, 16'h5678);
        chk("R2 multi cor sts", {25'd0, root_sts[6:0]}, 32'h03);
        chk("R2 multi cor src held", err_src_id, 32'h0000_1234);
    endtask

    task automatic t_cmd_msi();
        wr_cmd(3'b001);
        chk("R9 cmd raise pulse", {31'd0, msi_pulse}, 32'd1);
        chk("R6 cmd loaded", {29'd0, root_cmd}, 32'd1);
        wr_cmd(3'b001);
        chk("R9 cmd already true", {31'd0, msi_pulse}, 32'd0);
    endtask

    task automatic t_uncorrectable();
        clear_all();
        chk("R6 clear all", {25'd0, root_sts[6:0]}, 32'h00);
        send_msg(2'd1, 16'hAAAA);
        chk("R4 nonfatal sts", {25'd0, root_sts[6:0]}, 32'h24);
        chk("R3 first uncor src", err_src_id, 32'hAAAA_1234);
        chk("R8 nonfatal not enabled", {31'd0, msi_pulse}, 32'd0);
        send_msg(2'd2, 16'hBBBB);
        chk("R3 multi uncor no first fatal", {25'd0, root_sts[6:0]}, 32'h6C);
        chk("R3 uncor src held", err_src_id, 32'hAAAA_1234);
        clear_all();
        send_msg(2'd2, 16'hCCCC);
        chk("R4 first fatal", {25'd0, root_sts[6:0]}, 32'h54);
        chk("R3 fatal src", err_src_id, 32'hCCCC_1234);
    endtask

    task automatic t_msi_edges();
        wr_cmd(3'b111);
        chk("R9 cmd enables pending fatal", {31'd0, msi_pulse}, 32'd1);
        send_msg(2'd0, 16'h0101);
        chk("R8 no pulse when already true", {31'd0, msi_pulse}, 32'd0);
        chk("R2 cor after clear", err_src_id, 32'hCCCC_0101);
        clear_all();
        send_msg(2'd2, 16'h0202);
        chk("R8 pulse after clear", {31'd0, msi_pulse}, 32'd1);
        @(negedge clk);
        chk("R8 pulse one cycle", {31'd0, msi_pulse}, 32'd0);
    endtask

    task automatic t_reserved();
        clear_all();
        send_msg(2'd3, 16'hFFFF);
        chk("R5 reserved sts", {25'd0, root_sts[6:0]}, 32'h00);
        chk("R5 reserved src", err_src_id, 32'h0202_0101);
        chk("R5 reserved pulse", {31'd0, msi_pulse}, 32'd0);
    endtask

    task automatic t_same_cycle();
        send_msg(2'd0, 16'h1111);
        chk("R2 cor 1111", err_src_id, 32'h0202_1111);
        clear_all();
        send_msg(2'd0, 16'h1111);
        rpt_w1c = 7'h01;
        send_msg(2'd0, 16'h2222);
        rpt_w1c = 7'h00;
        chk("R6 msg wins over clear", {25'd0, root_sts[6:0]}, 32'h01);
        chk("R6 cleared flag recaptures src", err_src_id, 32'h0202_2222);
        chk("R6 clear plus msg pulses", {31'd0, msi_pulse}, 32'd1);
    endtask

    task automatic t_intx();
        msi_en = 1'b0;
        clear_all();
        wr_cmd(3'b010);
        chk("R10 intx low no status", {31'd0, intx_level}, 32'd0);
        send_msg(2'd1, 16'h3333);
        chk("R10 intx high", {31'd0, intx_level}, 32'd1);
        chk("R10 no msi pulse", {31'd0, msi_pulse}, 32'd0);
        wr_cmd(3'b000);
        chk("R10 cmd off drops intx", {31'd0, intx_level}, 32'd0);
        wr_cmd(3'b010);
        chk("R10 cmd on restores intx", {31'd0, intx_level}, 32'd1);
    endtask

    task automatic t_msgnum();
        msg_num_in = 5'd21;
        rpt_w1c = 7'h7f;
        @(negedge clk);
        rpt_w1c = 7'h00;
        chk("R7 msgnum follows input", {27'd0, root_sts[31:27]}, 32'd21);
        chk("R7 pad zero", {12'd0, root_sts[26:7]}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_correctable();
        t_cmd_msi();
        t_uncorrectable();
        t_msi_edges();
        t_reserved();
        t_same_cycle();
        t_intx();
        t_msgnum();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule